// File: doc/BRIEF.md
# Sequential Signed/Unsigned Shift-Add Multiplier

This block multiplies two WIDTH-bit operands over WIDTH clock cycles with a single adder/subtractor. A one-cycle `start` pulse captures the multiplicand, the multiplier and a mode bit that selects unsigned or two's-complement arithmetic. Each step looks at the lowest bit of the multiplier register. When that bit is 1 the multiplicand is added to the upper product half. When it is 0, zero is added. The joined upper half and multiplier register then shift right by one bit.

In two's-complement mode the step for the multiplier's top bit subtracts instead of adding, because that bit has negative weight. The upper half is kept one bit wider than WIDTH during the add, so the right shift carries the true sign into the vacated bit.

A three-state controller sequences the work. In `ST_IDLE` the block waits. The transition `IDLE->RUN` happens on `start`. `ST_RUN` performs WIDTH steps and `busy` is high throughout. `RUN->DONE` is taken after the last step. `ST_DONE` lasts one cycle with `done` high. From there, `DONE->RUN` is taken on a new `start`, and `DONE->IDLE` is taken otherwise. The product stays on `product` until the next accepted start.

Top module: `seq_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` pulse sampled while `busy` is 0 loads the operands and the mode bit (1 = two's complement, 0 = unsigned). From the next cycle on, `busy` is 1.
- R3: In unsigned mode, `product` equals the unsigned product of the two operands, as a 2*WIDTH-bit value.
- R4: In two's-complement mode, `product` equals the signed product in 2*WIDTH-bit two's complement, including when the multiplier is negative (the last partial product is subtracted). An example at WIDTH=3 is 101 x 110 = 000110.
- R5: In two's-complement mode, a negative multiplicand times a non-negative multiplier gives the sign-extended negative product. The upper half is filled with its sign on each shift.
- R6: `busy` stays high for exactly WIDTH cycles. `done` is then high for exactly one cycle, and `busy` and `done` are never high together.
- R7: A `start` seen while `busy` is 1 is ignored. The running result and its timing are unchanged.
- R8: After `done`, `product` holds its value and `done` stays low until the next accepted `start`.
- R9: Extreme operands give the exact result. In two's-complement mode, most negative times most negative gives 2^(2*WIDTH-2), and most negative times most positive is also exact. In unsigned mode, all ones times all ones is exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiply (one-cycle pulse) |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| mcand | input | WIDTH | Multiplicand |
| mplier | input | WIDTH | Multiplier |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Result, held until the next start |

## Verification
The hardest case to reach is a set multiplier top bit together with a sign-extended partial sum at the guard bit. This is where the final subtraction meets the arithmetic shift. The stimulus reaches it with a full sweep of every operand pair in both modes on a 3-bit instance. That sweep covers every combination of negative multiplicand, negative multiplier and zero lowest bit. It is backed by directed extreme operands on the 8-bit instance. A start pulse injected in the middle of a run checks that the result and the cycle count stay untouched.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;
endpackage

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

    mul_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST_CNT) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        last = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
                last = (cnt_q == LAST_CNT);
            end
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end

    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> done);
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> busy);
    a_r2_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/seqmul_datapath.sv
module seqmul_datapath #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               last,
    input  logic               is_signed,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic [2*WIDTH-1:0] product
);
    localparam int EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] a_q, p_q, b_q;
    logic             sgn_q;
    logic [EXT_W-1:0] a_ext, p_ext, addend, sum;
    logic             sub;

    // guard bit: sign-extended in two's complement mode, zero otherwise
    always_comb begin
        a_ext  = {sgn_q & a_q[WIDTH-1], a_q};
        p_ext  = {sgn_q & p_q[WIDTH-1], p_q};
        addend = b_q[0] ? a_ext : '0;
        sub    = sgn_q && last;
        sum    = sub ? (p_ext - addend) : (p_ext + addend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            p_q   <= '0;
            b_q   <= '0;
            sgn_q <= 1'b0;
        end else if (load) begin
            a_q   <= mcand;
            p_q   <= '0;
            b_q   <= mplier;
            sgn_q <= is_signed;
        end else if (step) begin
            p_q <= sum[EXT_W-1:1];
            b_q <= {sum[0], b_q[WIDTH-1:1]};
        end
    end

    assign product = {p_q, b_q};

    a_r7_operand_held: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> ($stable(a_q) && $stable(sgn_q)));
    a_r8_product_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(product));
    a_r3_unsigned_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !sgn_q) |-> !sub);
endmodule

// File: rtl/seq_mul.sv
module seq_mul #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               is_signed,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic load, step, last;

    seqmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .last  (last),
        .busy  (busy),
        .done  (done)
    );

    seqmul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .last      (last),
        .is_signed (is_signed),
        .mcand     (mcand),
        .mplier    (mplier),
        .product   (product)
    );

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: tb/seq_mul_tb.sv
module seq_mul_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // 8-bit instance
    logic        start = 1'b0, sgn = 1'b0;
    logic [7:0]  ma = '0, mb = '0;
    logic        busy, done;
    logic [15:0] prod;

    seq_mul #(.WIDTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(sgn),
        .mcand(ma), .mplier(mb), .busy(busy), .done(done), .product(prod)
    );

    // 3-bit instance
    logic       s3_start = 1'b0, s3_sgn = 1'b0;
    logic [2:0] s3_a = '0, s3_b = '0;
    logic       s3_busy, s3_done;
    logic [5:0] s3_prod;

    seq_mul #(.WIDTH(3)) u_dut_w3 (
        .clk(clk), .rst_n(rst_n), .start(s3_start), .is_signed(s3_sgn),
        .mcand(s3_a), .mplier(s3_b), .busy(s3_busy), .done(s3_done), .product(s3_prod)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b, input logic s);
        longint x;
        if (s) x = longint'($signed(a)) * longint'($signed(b));
        else   x = longint'(a) * longint'(b);
        return x[15:0];
    endfunction

    function automatic logic [5:0] ref3(input logic [2:0] a, input logic [2:0] b, input logic s);
        longint x;
        if (s) x = longint'($signed(a)) * longint'($signed(b));
        else   x = longint'(a) * longint'(b);
        return x[5:0];
    endfunction

    // run one 8-bit multiply; optional stray start mid-run
    task automatic mul8(input logic [7:0] a, input logic [7:0] b, input logic s,
                        input logic stray, output logic [15:0] res, output int bcyc);
        int guard = 0;
        @(negedge clk);
        ma = a; mb = b; sgn = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bcyc = 0;
        while (!done && guard < 100) begin
            if (busy) bcyc++;
            if (stray && bcyc == 3) begin
                ma = 8'h5A; mb = 8'hC3; sgn = ~s; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        res = prod;
    endtask

    task automatic mul3(input logic [2:0] a, input logic [2:0] b, input logic s,
                        output logic [5:0] res);
        int guard = 0;
        @(negedge clk);
        s3_a = a; s3_b = b; s3_sgn = s; s3_start = 1'b1;
        @(negedge clk);
        s3_start = 1'b0;
        while (!s3_done && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        res = s3_prod;
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", longint'(busy), 0);
        chk(done == 1'b0, "R1 done", longint'(done), 0);
        chk(prod == 16'h0, "R1 product", longint'(prod), 0);
    endtask

    task automatic t_start_busy();
        @(negedge clk);
        ma = 8'd3; mb = 8'd4; sgn = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
        while (!done) @(negedge clk);
        chk(prod == 16'd12, "R2 load", longint'(prod), 12);
    endtask

    task automatic t_unsigned();
        logic [15:0] r; int bc;
        mul8(8'd13, 8'd11, 1'b0, 1'b0, r, bc);
        chk(r == 16'd143, "R3 13x11", longint'(r), 143);
        mul8(8'hFB, 8'd3, 1'b0, 1'b0, r, bc);
        chk(r == 16'h02F1, "R3 FBx3", longint'(r), 16'h02F1);
        mul8(8'hC8, 8'hA5, 1'b0, 1'b0, r, bc);
        chk(r == ref8(8'hC8, 8'hA5, 1'b0), "R3 C8xA5", longint'(r), longint'(ref8(8'hC8, 8'hA5, 1'b0)));
        mul8(8'd0, 8'hFF, 1'b0, 1'b0, r, bc);
        chk(r == 16'h0, "R3 zero", longint'(r), 0);
    endtask

    task automatic t_signed();
        logic [15:0] r; int bc;
        mul8(8'd100, 8'hF9, 1'b1, 1'b0, r, bc);
        chk(r == 16'(-700), "R4 100x-7", longint'(r), longint'(16'(-700)));
        mul8(8'hF3, 8'hEE, 1'b1, 1'b0, r, bc);
        chk(r == ref8(8'hF3, 8'hEE, 1'b1), "R4 -13x-18", longint'(r), longint'(ref8(8'hF3, 8'hEE, 1'b1)));
        mul8(8'hFB, 8'd3, 1'b1, 1'b0, r, bc);
        chk(r == 16'hFFF1, "R5 -5x3", longint'(r), 16'hFFF1);
        mul8(8'h81, 8'd64, 1'b1, 1'b0, r, bc);
        chk(r == ref8(8'h81, 8'd64, 1'b1), "R5 -127x64", longint'(r), longint'(ref8(8'h81, 8'd64, 1'b1)));
    endtask

    task automatic t_extremes();
        logic [15:0] r; int bc;
        mul8(8'h80, 8'h80, 1'b1, 1'b0, r, bc);
        chk(r == 16'h4000, "R9 minxmin", longint'(r), 16'h4000);
        mul8(8'h80, 8'h7F, 1'b1, 1'b0, r, bc);
        chk(r == 16'hC080, "R9 minxmax", longint'(r), 16'hC080);
        mul8(8'hFF, 8'hFF, 1'b0, 1'b0, r, bc);
        chk(r == 16'hFE01, "R9 unsigned ones", longint'(r), 16'hFE01);
        mul8(8'hFF, 8'hFF, 1'b1, 1'b0, r, bc);
        chk(r == 16'h0001, "R4 -1x-1", longint'(r), 1);
    endtask

    task automatic t_timing();
        logic [15:0] r; int bc;
        mul8(8'd7, 8'd9, 1'b0, 1'b0, r, bc);
        chk(bc == 8, "R6 busy cycles", longint'(bc), 8);
        chk(done == 1'b1 && busy == 1'b0, "R6 done alone", longint'({busy, done}), 1);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", longint'(done), 0);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] r; int bc;
        mul8(8'd25, 8'hF6, 1'b1, 1'b1, r, bc);
        chk(r == 16'(-250), "R7 result kept", longint'(r), longint'(16'(-250)));
        chk(bc == 8, "R7 timing kept", longint'(bc), 8);
    endtask

    task automatic t_hold();
        logic [15:0] r; int bc;
        mul8(8'd200, 8'd150, 1'b0, 1'b0, r, bc);
        repeat (4) @(negedge clk);
        chk(prod == 16'd30000, "R8 product held", longint'(prod), 30000);
        chk(done == 1'b0 && busy == 1'b0, "R8 quiet", longint'({busy, done}), 0);
    endtask

    task automatic t_w3();
        logic [5:0] r;
        mul3(3'b101, 3'b110, 1'b1, r);
        chk(r == 6'b000110, "R4 w3 -3x-2", longint'(r), 6);
        mul3(3'b100, 3'b100, 1'b1, r);
        chk(r == 6'b010000, "R9 w3 minxmin", longint'(r), 16);
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    mul3(3'(i), 3'(j), m[0], r);
                    chk(r == ref3(3'(i), 3'(j), m[0]), m[0] ? "R4 w3 sweep" : "R3 w3 sweep",
                        longint'(r), longint'(ref3(3'(i), 3'(j), m[0])));
                end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_start_busy();
        t_unsigned();
        t_signed();
        t_extremes();
        t_timing();
        t_busy_ignore();
        t_hold();
        t_w3();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule